// File: doc/BRIEF.md
# Banked Byte-Addressed Register File

This block is a small register file of eight banks, each bank holding 64 bytes. Within a bank every byte has its own address. Two 64-bit write ports and one 64-bit read port each take their own 19-bit control word. The control word picks the bank, one or two byte addresses, the direction, a split flag and the access size. An access may start at any byte offset. A multi-byte access that runs past the last byte of a bank continues at byte 0 of that same bank, so no access ever reaches a neighbouring bank.

A split read returns two 32-bit words from two independent byte addresses in the same bank in one access. Data is little-endian: the least significant byte of a port's data goes to, or comes from, the start address. Higher bytes follow at rising addresses.

The read result is registered. It holds its value until the next enabled read. An active-low global enable freezes the block: no writes take effect and the read result does not change. The ports are plain, without any handshake. Every control word presented with the enable low is accepted in that cycle, and there is no back-pressure.

Top module: `rf_banked`

## Requirements
- R1: A control word is packed as bank[18:16], first address[15:10], second address[9:4], direction[3] (1 = read, 0 = write), split[2] and size[1:0].
- R2: The size field selects the number of bytes: 11 = 8 bytes, 10 = 4 bytes, 00 = 2 bytes, 01 = 1 byte. A write changes only those bytes. On a read, the byte lanes above the size come out as zero.
- R3: Byte k of an access (bits 8k+7:8k) maps to address (first address + k) mod 64 in the selected bank. Wrap-around stays inside that bank.
- R4: A read with split = 1 and size = 10 returns 4 bytes from the first address in bits 31:0 and 4 bytes from the second address in bits 63:32, both in the same bank. With any other size, or on a write, split is ignored.
- R5: A write port whose control word has direction = 1 writes nothing.
- R6: When both write ports write the same byte in one cycle, port B's byte is stored.
- R7: The read result appears on rd_data one clock edge after the read control word is presented. A write is visible to a read presented in the next cycle. A read in the same cycle as a write returns the old content.
- R8: When the read control word has direction = 0, rd_data holds its previous value.
- R9: While en_n = 1, no byte is written and rd_data holds its value.
- R10: An active-low reset clears rd_data to zero. The stored contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the read result |
| en_n | input | 1 | Active-low global enable for all ports |
| wa_data | input | 64 | Write data for port A |
| wa_ctl | input | 19 | Control word for write port A |
| wb_data | input | 64 | Write data for port B |
| wb_ctl | input | 19 | Control word for write port B |
| rd_ctl | input | 19 | Control word for the read port |
| rd_data | output | 64 | Registered read result |

## Verification
Each read result is due exactly one rising edge after its control word is driven. A write becomes observable only through a read issued in the following cycle. The driver applies one cycle's stimulus at a falling edge and queues the value rd_data must show after the next rising edge. A same-cycle read queues the content from before that cycle's writes. The monitor pops one expected value per cycle, 1 ns after each rising edge, so every result is compared in the cycle it is due and at no other time.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;
  localparam int RF_BANKS      = 8;
  localparam int RF_BANK_BYTES = 64;
  localparam int RF_LANES      = 8;
  localparam int WPORTS        = 2;
  localparam int BANK_W        = $clog2(RF_BANKS);
  localparam int OFS_W         = $clog2(RF_BANK_BYTES);
  localparam int ADDR_W        = BANK_W + OFS_W;
  localparam int DATA_W        = 8 * RF_LANES;
  localparam int CTL_W         = BANK_W + 2 * OFS_W + 4;
  localparam int MEM_BYTES     = RF_BANKS * RF_BANK_BYTES;

  typedef enum logic [1:0] {
    SZ2 = 2'b00,
    SZ1 = 2'b01,
    SZ4 = 2'b10,
    SZ8 = 2'b11
  } size_e;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [OFS_W-1:0]  a1;
    logic [OFS_W-1:0]  a2;
    logic              rd;
    logic              split;
    size_e             size;
  } rf_ctl_t;

  function automatic int size_lanes(size_e s);
    case (s)
      SZ8:     return 8;
      SZ4:     return 4;
      SZ2:     return 2;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/rf_wr_lane.sv
`timescale 1ns/1ps
module rf_wr_lane
  import rf_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              en_n,
  input  rf_ctl_t                           ctl,
  input  logic [DATA_W-1:0]                 data,
  output logic [RF_LANES-1:0][ADDR_W-1:0]   lane_addr,
  output logic [RF_LANES-1:0][7:0]          lane_byte,
  output logic [RF_LANES-1:0]               lane_we
);
  logic active;
  logic unused_fields;
  assign active        = !en_n && !ctl.rd;
  assign unused_fields = ^{ctl.a2, ctl.split};

  for (genvar k = 0; k < RF_LANES; k++) begin : g_lane
    logic [OFS_W-1:0] ofs;
    assign ofs          = ctl.a1 + OFS_W'(k);
    assign lane_addr[k] = {ctl.bank, ofs};
    assign lane_byte[k] = data[8*k +: 8];
    assign lane_we[k]   = active && (k < size_lanes(ctl.size));
  end

  // R2: enabled lanes always form a run starting at lane 0
  p_we_contig_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((lane_we & (lane_we + RF_LANES'(1))) == '0));

  // R2: a single-byte write enables exactly one lane
  p_byte_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && !ctl.rd && ctl.size == SZ1) |-> ($countones(lane_we) == 1));

  // R5, R9: read direction or global disable keeps every lane quiet
  p_rdir_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_n || ctl.rd) |-> (lane_we == '0));
endmodule

// File: rtl/rf_rd_lane.sv
`timescale 1ns/1ps
module rf_rd_lane
  import rf_pkg::*;
(
  input  rf_ctl_t                           ctl,
  output logic [RF_LANES-1:0][ADDR_W-1:0]   lane_addr,
  output logic [RF_LANES-1:0]               lane_on
);
  localparam int HALF = RF_LANES / 2;

  logic dual;
  logic unused_dir;
  assign dual       = ctl.split && (ctl.size == SZ4);
  assign unused_dir = ctl.rd;

  for (genvar k = 0; k < RF_LANES; k++) begin : g_lane
    logic [OFS_W-1:0] o1;
    assign o1 = ctl.a1 + OFS_W'(k);
    if (k >= HALF) begin : g_hi
      logic [OFS_W-1:0] o2;
      assign o2           = ctl.a2 + OFS_W'(k - HALF);
      assign lane_addr[k] = dual ? {ctl.bank, o2} : {ctl.bank, o1};
      assign lane_on[k]   = dual || (k < size_lanes(ctl.size));
    end else begin : g_lo
      assign lane_addr[k] = {ctl.bank, o1};
      assign lane_on[k]   = (k < size_lanes(ctl.size));
    end
  end
endmodule

// File: rtl/rf_banked.sv
`timescale 1ns/1ps
module rf_banked
  import rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic [DATA_W-1:0] wa_data,
  input  logic [CTL_W-1:0]  wa_ctl,
  input  logic [DATA_W-1:0] wb_data,
  input  logic [CTL_W-1:0]  wb_ctl,
  input  logic [CTL_W-1:0]  rd_ctl,
  output logic [DATA_W-1:0] rd_data
);
  rf_ctl_t           wctl [WPORTS];
  logic [DATA_W-1:0] wdat [WPORTS];
  rf_ctl_t           rctl;

  assign wctl[0] = rf_ctl_t'(wa_ctl);
  assign wctl[1] = rf_ctl_t'(wb_ctl);
  assign wdat[0] = wa_data;
  assign wdat[1] = wb_data;
  assign rctl    = rf_ctl_t'(rd_ctl);

  logic [WPORTS-1:0][RF_LANES-1:0][ADDR_W-1:0] w_addr;
  logic [WPORTS-1:0][RF_LANES-1:0][7:0]        w_byte;
  logic [WPORTS-1:0][RF_LANES-1:0]             w_we;

  for (genvar p = 0; p < WPORTS; p++) begin : g_wport
    rf_wr_lane u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_n      (en_n),
      .ctl       (wctl[p]),
      .data      (wdat[p]),
      .lane_addr (w_addr[p]),
      .lane_byte (w_byte[p]),
      .lane_we   (w_we[p])
    );
  end

  logic [RF_LANES-1:0][ADDR_W-1:0] r_addr;
  logic [RF_LANES-1:0]             r_on;

  rf_rd_lane u_rd (
    .ctl       (rctl),
    .lane_addr (r_addr),
    .lane_on   (r_on)
  );

  logic [7:0] mem [MEM_BYTES];

  // later port in the loop overrides earlier one: port B wins (R6)
  always_ff @(posedge clk) begin
    for (int p = 0; p < WPORTS; p++) begin
      for (int k = 0; k < RF_LANES; k++) begin
        if (w_we[p][k]) mem[w_addr[p][k]] <= w_byte[p][k];
      end
    end
  end

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    for (int k = 0; k < RF_LANES; k++) begin
      rd_next[8*k +: 8] = r_on[k] ? mem[r_addr[k]] : 8'h00;
    end
  end

  logic rd_go;
  assign rd_go = !en_n && rctl.rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_go) rd_data <= rd_next;
  end

  // R10: reset leaves a zero result
  p_reset_zero_r10: assert property (@(posedge clk)
    !rst_n |=> (rd_data == '0));

  // R9: disabled cycle leaves the result untouched
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |=> $stable(rd_data));

  // R8: no read request leaves the result untouched
  p_noread_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rctl.rd |=> $stable(rd_data));

  // R2: single-byte read clears the upper lanes
  p_byte_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && rctl.size == SZ1) |=> (rd_data[DATA_W-1:8] == '0));

  // R2: two-byte read clears the upper lanes
  p_half_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && rctl.size == SZ2) |=> (rd_data[DATA_W-1:16] == '0));
endmodule

// File: tb/sim_rf_banked.sv
`timescale 1ns/1ps
module sim_rf_banked;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, en_n;
  logic [63:0] wa_data, wb_data, rd_data;
  logic [18:0] wa_ctl, wb_ctl, rd_ctl;

  rf_banked u0 (
    .clk(clk), .rst_n(rst_n), .en_n(en_n),
    .wa_data(wa_data), .wa_ctl(wa_ctl),
    .wb_data(wb_data), .wb_ctl(wb_ctl),
    .rd_ctl(rd_ctl), .rd_data(rd_data)
  );

  logic [7:0]  model [512];
  logic [63:0] exp_rd;
  logic [63:0] q_exp [$];
  string       q_tag [$];
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 0;

  function automatic logic [18:0] cw(input logic [2:0] b, input logic [5:0] a1,
      input logic [5:0] a2, input logic r, input logic s, input logic [1:0] z);
    return {b, a1, a2, r, s, z};
  endfunction

  function automatic int nb(input logic [1:0] z);
    case (z)
      2'b11: return 8;
      2'b10: return 4;
      2'b00: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic logic [63:0] pat(input int n);
    logic [31:0] x;
    x = n;
    return {(x * 32'h9E3779B1) ^ 32'h1234_5678, (x + 7) * 32'h85EBCA6B};
  endfunction

  function automatic logic [63:0] mread(input logic [18:0] c);
    logic [63:0] r;
    int b, a1, a2, n;
    r = '0; b = c[18:16]; a1 = c[15:10]; a2 = c[9:4]; n = nb(c[1:0]);
    if (c[2] && c[1:0] == 2'b10) begin
      for (int k = 0; k < 4; k++) begin
        r[8*k +: 8]      = model[b*64 + (a1 + k) % 64];
        r[32 + 8*k +: 8] = model[b*64 + (a2 + k) % 64];
      end
    end else begin
      for (int k = 0; k < n; k++) r[8*k +: 8] = model[b*64 + (a1 + k) % 64];
    end
    return r;
  endfunction

  function automatic void mwrite(input logic [18:0] c, input logic [63:0] d);
    int b, a1, n;
    b = c[18:16]; a1 = c[15:10]; n = nb(c[1:0]);
    if (!c[3]) for (int k = 0; k < n; k++) model[b*64 + (a1 + k) % 64] = d[8*k +: 8];
  endfunction

  task automatic check(input string t, input logic [63:0] act, input logic [63:0] e);
    n_cmp++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", t, act, e);
    end
  endtask

  // driver: one cycle of stimulus, expected result queued for the next edge
  task automatic step(input logic en, input logic [63:0] da, input logic [63:0] db,
      input logic [18:0] ca, input logic [18:0] cb, input logic [18:0] cr, input string t);
    @(negedge clk);
    en_n = en; wa_data = da; wb_data = db; wa_ctl = ca; wb_ctl = cb; rd_ctl = cr;
    if (!en) begin
      if (cr[3]) exp_rd = mread(cr);
      mwrite(ca, da);
      mwrite(cb, db);
    end
    q_exp.push_back(exp_rd);
    q_tag.push_back(t);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_exp.size() > 0) begin
        logic [63:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check(t, rd_data, e);
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  localparam logic [18:0] NOWR = 19'h0000F; // direction=1 on a write port
  localparam logic [18:0] NORD = 19'h00003; // direction=0 on the read port

  initial begin
    rst_n = 0; en_n = 1; wa_data = '0; wb_data = '0;
    wa_ctl = NOWR; wb_ctl = NOWR; rd_ctl = NORD; exp_rd = '0;
    repeat (3) @(negedge clk);
    check("R10 reset result", rd_data, 64'h0);
    rst_n = 1;

    // fill every bank; read port idle so result must stay zero (R8, R10)
    for (int i = 0; i < 32; i++)
      step(0, pat(2*i), pat(2*i+1), cw(i/4, (i%4)*16, 0, 0, 0, 2'b11),
           cw(i/4, (i%4)*16 + 8, 0, 0, 0, 2'b11), NORD, "R8 hold during fill");

    step(0, 0, 0, NOWR, NOWR, cw(1, 8, 0, 1, 0, 2'b11), "R1 field read bank1 addr8");
    step(0, 0, 0, NOWR, NOWR, cw(5, 63, 0, 1, 0, 2'b11), "R3 wrap read at 63");
    step(0, 0, 0, NOWR, NOWR, cw(2, 62, 0, 1, 0, 2'b10), "R2 4-byte read wrapped");
    step(0, 0, 0, NOWR, NOWR, cw(3, 10, 0, 1, 0, 2'b00), "R2 2-byte read");
    step(0, 0, 0, NOWR, NOWR, cw(4, 33, 0, 1, 0, 2'b01), "R2 1-byte read");
    step(0, 0, 0, NOWR, NOWR, cw(6, 5, 50, 1, 1, 2'b10), "R4 split read");
    step(0, 0, 0, NOWR, NOWR, cw(6, 5, 50, 1, 1, 2'b11), "R4 split ignored size8");
    step(0, 0, 0, NOWR, NOWR, cw(6, 61, 50, 1, 1, 2'b01), "R4 split ignored size1");

    // write port in read direction writes nothing
    step(0, 64'hFFFF_FFFF_FFFF_FFFF, 0, cw(0, 0, 0, 1, 0, 2'b11), NOWR, NORD, "R8 hold");
    step(0, 0, 0, NOWR, NOWR, cw(0, 0, 0, 1, 0, 2'b11), "R5 read-direction write ignored");

    // collision: B wins on overlapping bytes
    step(0, 64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD,
         cw(7, 4, 0, 0, 0, 2'b11), cw(7, 8, 0, 0, 0, 2'b10),
         cw(7, 4, 0, 1, 0, 2'b11), "R7 same-cycle read old data");
    step(0, 0, 0, NOWR, NOWR, cw(7, 4, 0, 1, 0, 2'b11), "R6 port B wins");

    // write then next-cycle read
    step(0, 64'h0123_4567_89AB_CDEF, 0, cw(1, 0, 0, 0, 0, 2'b11), NOWR,
         cw(1, 0, 0, 1, 0, 2'b11), "R7 same-cycle read old data");
    step(0, 0, 0, NOWR, NOWR, cw(1, 0, 0, 1, 0, 2'b11), "R7 write visible next cycle");

    // single byte write changes one byte only
    step(0, 64'h5A5A_5A5A_5A5A_5AAB, 0, cw(2, 20, 0, 0, 0, 2'b01), NOWR, NORD, "R8 hold");
    step(0, 0, 0, NOWR, NOWR, cw(2, 16, 0, 1, 0, 2'b11), "R2 byte write only one byte");

    // wrapping write stays in bank 2
    step(0, 64'hC0C1_C2C3_C4C5_C6C7, 0, cw(2, 60, 0, 0, 0, 2'b11), NOWR, NORD, "R8 hold");
    step(0, 0, 0, NOWR, NOWR, cw(3, 0, 0, 1, 0, 2'b11), "R3 neighbour bank untouched");
    step(0, 0, 0, NOWR, NOWR, cw(2, 0, 0, 1, 0, 2'b11), "R3 write wrapped to byte 0");

    // split flag on a write acts as a plain write
    step(0, 64'h7777_8888_9999_AAAA, 0, cw(4, 30, 40, 0, 1, 2'b10), NOWR, NORD, "R8 hold");
    step(0, 0, 0, NOWR, NOWR, cw(4, 28, 0, 1, 0, 2'b11), "R4 split ignored on write");

    // global disable: no write, no read update
    step(1, 64'hDEAD_DEAD_DEAD_DEAD, 64'hBEEF_BEEF_BEEF_BEEF, cw(0, 0, 0, 0, 0, 2'b11),
         cw(0, 8, 0, 0, 0, 2'b11), cw(0, 8, 0, 1, 0, 2'b11), "R9 disabled holds result");
    step(0, 0, 0, NOWR, NOWR, cw(0, 0, 0, 1, 0, 2'b11), "R9 disabled wrote nothing A");
    step(0, 0, 0, NOWR, NOWR, cw(0, 8, 0, 1, 0, 2'b11), "R9 disabled wrote nothing B");

    step(0, 0, 0, NOWR, NOWR, NORD, "R8 no read holds");

    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule